// File: doc/BRIEF.md
# Three-Client Shared Packet Buffer Arbiter

This block lets three clients share one single-port packet memory as if each had a port of its own. A receive client pushes words that are stored in the receive region. A transmit client pulls words that are prefetched from the transmit region. A host client either loads words into the transmit region or drains words from the receive region. Which of the two it does is chosen each time its pointer is loaded. Each client has a small FIFO, so one memory access per clock can be spread across the clients while none of them stalls for long.

Surrounding logic programs each region's lower and upper word addresses. It loads each client's start address, and for the read clients a word count, through a one-cycle load pulse. After that, data moves through plain valid/ready handshakes. The memory is a synchronous single-port RAM with one cycle of read latency. Each read is tagged with the client it belongs to, and the returning word is steered into that client's FIFO.

Top module: `pktbuf_arbiter`

## Requirements
- R1: The block issues at most one memory access per clock. `mem_we` is high only for a receive grant or a host grant in write mode, and a client is granted only when it has pending work.
- R2: Receive words are written to consecutive addresses starting at `rx_start`, wrapping from `rx_hi` back to `rx_lo`. `rx_ready` is low only while the receive FIFO holds FD words.
- R3: With `host_dir`=1 (write), accepted host words are stored in order from `host_start` in the transmit region, wrapping from `tx_hi` to `tx_lo`.
- R4: With `host_dir`=0 (read), exactly `host_len` words are fetched in order from `host_start` in the receive region, wrapping at `rx_hi`, and are delivered on `host_rdata` under `host_rvalid`/`host_rready`. In this mode `host_wready` stays 0.
- R5: After a transmit load, exactly `tx_len` words are delivered in order from `tx_start` in the transmit region, wrapping at `tx_hi`, whatever the `tx_ready` pattern. After the last word, `tx_valid` stays 0.
- R6: Read data returns one cycle after its grant and enters only the FIFO of the client that was granted, so host reads and transmit reads can run at the same time without mixing.
- R7: Outside receive urgency, grants rotate round-robin: a requesting client sees at most two grants to other clients before its own.
- R8: When the receive FIFO holds HIWAT or more words, the receive client wins the memory. A receive stream of one word every other cycle is never refused, even while host and transmit both contend.
- R9: During and right after reset, `mem_en`, `host_wready`, `host_rvalid` and `tx_valid` are 0 and `rx_ready` is 1.
- R10: A load pulse empties that client's FIFO and discards its in-flight read. The first word delivered after a transmit reload comes from the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_lo | input | AW | Receive region lowest word address |
| rx_hi | input | AW | Receive region highest word address |
| tx_lo | input | AW | Transmit region lowest word address |
| tx_hi | input | AW | Transmit region highest word address |
| rx_load | input | 1 | Load receive pointer pulse |
| rx_start | input | AW | Receive start address |
| rx_valid | input | 1 | Receive word offered |
| rx_data | input | DW | Receive word |
| rx_ready | output | 1 | Receive FIFO can accept |
| tx_load | input | 1 | Load transmit pointer and count pulse |
| tx_start | input | AW | Transmit start address |
| tx_len | input | AW+1 | Transmit word count |
| tx_valid | output | 1 | Transmit word available |
| tx_data | output | DW | Transmit word |
| tx_ready | input | 1 | Transmit consumer takes word |
| host_load | input | 1 | Load host pointer, count and direction pulse |
| host_dir | input | 1 | 1 = write transmit region, 0 = read receive region |
| host_start | input | AW | Host start address |
| host_len | input | AW+1 | Host read word count |
| host_wvalid | input | 1 | Host write word offered |
| host_wdata | input | DW | Host write word |
| host_wready | output | 1 | Host write FIFO can accept |
| host_rvalid | output | 1 | Host read word available |
| host_rdata | output | DW | Host read word |
| host_rready | input | 1 | Host takes read word |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The assertions assume that region bounds satisfy lo <= hi and hold steady, and that every start address lies inside its region. The region-address checks and the round-robin wait bound depend on that. The urgency and no-refusal properties also assume the receive client offers at most one word every other cycle, so urgent grants leave room for the others. The stimulus keeps fixed regions, loads only in-region start addresses, spaces receive words by one idle cycle, and reloads the transmit client only while its consumer is stalled.

// File: rtl/pktbuf_arbiter.sv
module pktbuf_arbiter #(
  parameter int DW    = 16,
  parameter int AW    = 10,
  parameter int FD    = 4,
  parameter int HIWAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rx_lo,
  input  logic [AW-1:0] rx_hi,
  input  logic [AW-1:0] tx_lo,
  input  logic [AW-1:0] tx_hi,
  input  logic          rx_load,
  input  logic [AW-1:0] rx_start,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  input  logic          tx_load,
  input  logic [AW-1:0] tx_start,
  input  logic [AW:0]   tx_len,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          host_load,
  input  logic          host_dir,
  input  logic [AW-1:0] host_start,
  input  logic [AW:0]   host_len,
  input  logic          host_wvalid,
  input  logic [DW-1:0] host_wdata,
  output logic          host_wready,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  input  logic          host_rready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int FAW = $clog2(FD);
  localparam int CW  = FAW + 1;

  logic [DW-1:0]  fq [3][FD];
  logic [FAW-1:0] wp [3];
  logic [FAW-1:0] rp [3];
  logic [CW-1:0]  cnt [3];
  logic [DW-1:0]  din [3];
  logic [DW-1:0]  head [3];
  logic [2:0]     push, pop, flush, req, gnt, full, empty;
  logic [AW-1:0]  rx_ptr, hs_ptr, tx_ptr;
  logic [AW:0]    hs_left, tx_left;
  logic           hs_dir, rt_h, rt_t, urgent;
  logic [1:0]     last;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, lo, hi);
    return (p == hi) ? lo : p + 1'b1;
  endfunction

  for (genvar i = 0; i < 3; i++) begin : g_st
    assign full[i]  = (cnt[i] == CW'(FD));
    assign empty[i] = (cnt[i] == '0);
    assign head[i]  = fq[i][rp[i]];
  end

  assign flush  = {tx_load, host_load, rx_load};
  assign req[0] = !empty[0] && !rx_load;
  assign req[1] = !host_load && (hs_dir ? !empty[1]
                  : (hs_left != '0 && (32'(cnt[1]) + 32'(rt_h)) < FD));
  assign req[2] = !tx_load && tx_left != '0 && (32'(cnt[2]) + 32'(rt_t)) < FD;
  assign urgent = req[0] && 32'(cnt[0]) >= HIWAT;

  always_comb begin
    int j;
    j   = 0;
    gnt = '0;
    if (urgent) gnt = 3'b001;
    else
      for (int k = 1; k <= 3; k++) begin
        j = (int'(last) + k) % 3;
        if (gnt == '0 && req[j]) gnt[j] = 1'b1;
      end
  end

  assign push[0] = rx_valid && !full[0];
  assign push[1] = hs_dir ? (host_wvalid && !full[1]) : rt_h;
  assign push[2] = rt_t;
  assign pop[0]  = gnt[0];
  assign pop[1]  = hs_dir ? gnt[1] : (host_rready && !empty[1]);
  assign pop[2]  = tx_ready && !empty[2];
  assign din[0]  = rx_data;
  assign din[1]  = hs_dir ? host_wdata : mem_rdata;
  assign din[2]  = mem_rdata;

  always_ff @(posedge clk)
    for (int i = 0; i < 3; i++)
      if (push[i] && !flush[i]) fq[i][wp[i]] <= din[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (flush[i]) begin
          wp[i]  <= '0;
          rp[i]  <= '0;
          cnt[i] <= '0;
        end else begin
          if (push[i]) wp[i] <= wp[i] + 1'b1;
          if (pop[i])  rp[i] <= rp[i] + 1'b1;
          cnt[i] <= cnt[i] + CW'(push[i]) - CW'(pop[i]);
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_ptr  <= '0;
      hs_ptr  <= '0;
      tx_ptr  <= '0;
      hs_left <= '0;
      tx_left <= '0;
      hs_dir  <= 1'b0;
      rt_h    <= 1'b0;
      rt_t    <= 1'b0;
      last    <= '0;
    end else begin
      rt_h <= gnt[1] && !hs_dir;
      rt_t <= gnt[2];
      if (gnt != '0 && !urgent) last <= gnt[1] ? 2'd1 : (gnt[2] ? 2'd2 : 2'd0);

      if (rx_load)     rx_ptr <= rx_start;
      else if (gnt[0]) rx_ptr <= step(rx_ptr, rx_lo, rx_hi);

      if (host_load) begin
        hs_ptr  <= host_start;
        hs_left <= host_len;
        hs_dir  <= host_dir;
      end else if (gnt[1]) begin
        hs_ptr <= hs_dir ? step(hs_ptr, tx_lo, tx_hi) : step(hs_ptr, rx_lo, rx_hi);
        if (!hs_dir) hs_left <= hs_left - 1'b1;
      end

      if (tx_load) begin
        tx_ptr  <= tx_start;
        tx_left <= tx_len;
      end else if (gnt[2]) begin
        tx_ptr  <= step(tx_ptr, tx_lo, tx_hi);
        tx_left <= tx_left - 1'b1;
      end
    end

  assign rx_ready    = !full[0];
  assign tx_valid    = !empty[2];
  assign tx_data     = head[2];
  assign host_wready = hs_dir && !full[1];
  assign host_rvalid = !hs_dir && !empty[1];
  assign host_rdata  = head[1];
  assign mem_en      = gnt != '0;
  assign mem_we      = gnt[0] || (gnt[1] && hs_dir);
  assign mem_addr    = gnt[0] ? rx_ptr : (gnt[1] ? hs_ptr : tx_ptr);
  assign mem_wdata   = gnt[0] ? head[0] : head[1];
endmodule

// File: rtl/pktbuf_arbiter_chk.sv
module pktbuf_arbiter_chk #(
  parameter int AW    = 10,
  parameter int FD    = 4,
  parameter int HIWAT = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           gnt,
  input logic [2:0]           req,
  input logic [$clog2(FD):0]  cnt0,
  input logic [$clog2(FD):0]  cnt1,
  input logic [$clog2(FD):0]  cnt2,
  input logic                 mem_en,
  input logic                 mem_we,
  input logic [AW-1:0]        mem_addr,
  input logic [AW-1:0]        rx_lo,
  input logic [AW-1:0]        rx_hi,
  input logic [AW-1:0]        tx_lo,
  input logic [AW-1:0]        tx_hi,
  input logic                 rt_h,
  input logic                 rt_t,
  input logic                 hs_dir
);
  logic [1:0] wt [3];
  logic       urg;

  assign urg = req[0] && 32'(cnt0) >= HIWAT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) wt[i] <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        if (!req[i] || gnt[i]) wt[i] <= '0;
        else if (!urg)         wt[i] <= wt[i] + 1'b1;
    end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == 3'b000));

  // R1
  write_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (gnt[0] || (gnt[1] && hs_dir)));

  // R6
  read_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (rt_h != rt_t));

  // R8
  rx_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urg |-> gnt[0]);

  // R7
  rr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt[0] <= 2'd2 && wt[1] <= 2'd2 && wt[2] <= 2'd2);

  // R2
  rx_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |-> (mem_addr >= rx_lo && mem_addr <= rx_hi));

  // R5
  tx_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[2] |-> (mem_addr >= tx_lo && mem_addr <= tx_hi));

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt0) <= FD && 32'(cnt1) <= FD && 32'(cnt2) <= FD);
endmodule

bind pktbuf_arbiter pktbuf_arbiter_chk #(.AW(AW), .FD(FD), .HIWAT(HIWAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req),
  .cnt0(cnt[0]), .cnt1(cnt[1]), .cnt2(cnt[2]),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .rx_lo(rx_lo), .rx_hi(rx_hi), .tx_lo(tx_lo), .tx_hi(tx_hi),
  .rt_h(rt_h), .rt_t(rt_t), .hs_dir(hs_dir)
);

// File: tb/tb_pktbuf_arbiter.sv
module tb_pktbuf_arbiter;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam logic [AW-1:0] RXLO = 10'd16, RXHI = 10'd23;
  localparam logic [AW-1:0] TXLO = 10'd64, TXHI = 10'd95;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rx_load = 0, rx_valid = 0, tx_load = 0, tx_ready = 0;
  logic          host_load = 0, host_dir = 0, host_wvalid = 0, host_rready = 0;
  logic [AW-1:0] rx_start = 0, tx_start = 0, host_start = 0;
  logic [AW:0]   tx_len = 0, host_len = 0;
  logic [DW-1:0] rx_data = 0, host_wdata = 0, mem_rdata = 0;
  logic          rx_ready, tx_valid, host_wready, host_rvalid, mem_en, mem_we;
  logic [DW-1:0] tx_data, host_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  pktbuf_arbiter dut (
    .clk(clk), .rst_n(rst_n), .rx_lo(RXLO), .rx_hi(RXHI), .tx_lo(TXLO), .tx_hi(TXHI),
    .rx_load(rx_load), .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_load(tx_load), .tx_start(tx_start), .tx_len(tx_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .host_load(host_load), .host_dir(host_dir), .host_start(host_start),
    .host_len(host_len), .host_wvalid(host_wvalid), .host_wdata(host_wdata),
    .host_wready(host_wready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .host_rready(host_rready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] ram [1<<AW];
  logic [DW-1:0] sh  [1<<AW];
  logic [DW-1:0] q_t [$];
  logic [DW-1:0] q_h [$];
  int checks = 0, errors = 0, rx_waits = 0;
  logic tx_stall = 0;

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata     <= ram[mem_addr];
    end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, lo, hi);
    return (p == hi) ? lo : p + 1'b1;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: consumers and comparisons
  always @(negedge clk) begin
    tx_ready    = !tx_stall && ($urandom_range(3) != 0);
    host_rready = ($urandom_range(4) != 0);
    if (tx_valid && tx_ready) begin
      if (q_t.size() == 0) check("R5 extra transmit word", tx_data, 16'hxxxx);
      else check("R5 R6 transmit data", tx_data, q_t.pop_front());
    end
    if (host_rvalid && host_rready) begin
      if (q_h.size() == 0) check("R4 extra host word", host_rdata, 16'hxxxx);
      else check("R4 R6 host read data", host_rdata, q_h.pop_front());
    end
  end

  task automatic rx_stream(input logic [AW-1:0] start, input int n, input int gap);
    logic [AW-1:0] a;
    @(negedge clk); rx_load = 1; rx_start = start;
    @(negedge clk); rx_load = 0; a = start;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = DW'(16'h1100 + i * 7 + int'(start));
      while (!rx_ready) begin rx_waits++; @(negedge clk); end
      @(negedge clk);
      sh[a] = rx_data; a = nxt(a, RXLO, RXHI);
      rx_valid = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] start, input int n);
    logic [AW-1:0] a;
    @(negedge clk); host_load = 1; host_dir = 1; host_start = start; host_len = 0;
    @(negedge clk); host_load = 0; a = start;
    for (int i = 0; i < n; i++) begin
      host_wvalid = 1; host_wdata = DW'(16'h2200 + i + int'(start));
      while (!host_wready) @(negedge clk);
      @(negedge clk);
      sh[a] = host_wdata; a = nxt(a, TXLO, TXHI);
    end
    host_wvalid = 0;
  endtask

  task automatic host_read(input logic [AW-1:0] start, input int n);
    logic [AW-1:0] a;
    a = start;
    for (int i = 0; i < n; i++) begin q_h.push_back(sh[a]); a = nxt(a, RXLO, RXHI); end
    @(negedge clk); host_load = 1; host_dir = 0; host_start = start; host_len = (AW+1)'(n);
    @(negedge clk); host_load = 0;
  endtask

  task automatic tx_read(input logic [AW-1:0] start, input int n);
    logic [AW-1:0] a;
    a = start;
    for (int i = 0; i < n; i++) begin q_t.push_back(sh[a]); a = nxt(a, TXLO, TXHI); end
    @(negedge clk); tx_load = 1; tx_start = start; tx_len = (AW+1)'(n);
    @(negedge clk); tx_load = 0;
  endtask

  task automatic wait_drain(input string tag);
    int t;
    t = 0;
    while ((q_t.size() != 0 || q_h.size() != 0) && t < 3000) begin @(negedge clk); t++; end
    check(tag, DW'(t < 3000), 16'd1);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin
      ram[a] = (a >= int'(TXLO) && a <= int'(TXHI)) ? DW'(16'hA000 + a) : '0;
      sh[a]  = ram[a];
    end
    repeat (3) @(negedge clk);
    // R9 during reset
    check("R9 mem_en in reset", DW'(mem_en), 16'd0);
    check("R9 rx_ready in reset", DW'(rx_ready), 16'd1);
    rst_n = 1;
    @(negedge clk);
    check("R9 host_wready after reset", DW'(host_wready), 16'd0);
    check("R9 host_rvalid after reset", DW'(host_rvalid), 16'd0);
    check("R9 tx_valid after reset", DW'(tx_valid), 16'd0);
    check("R9 mem_en after reset", DW'(mem_en), 16'd0);

    // receive store, host load and transmit fetch together (R2 R3 R5 R7)
    fork
      rx_stream(10'd20, 12, 1);
      host_write(10'd80, 10);
      tx_read(10'd90, 12);
    join
    wait_drain("R7 concurrent phase drains");
    repeat (5) @(negedge clk);

    // host read of receive region alongside transmit read (R4 R6)
    fork
      host_read(10'd16, 8);
      tx_read(10'd64, 6);
    join
    wait_drain("R7 dual read phase drains");
    repeat (5) @(negedge clk);
    check("R4 host_wready low in read mode", DW'(host_wready), 16'd0);
    check("R4 host_rvalid low after count", DW'(host_rvalid), 16'd0);

    // R10 transmit reload discards prefetched words
    tx_stall = 1;
    repeat (2) @(negedge clk);
    @(negedge clk); tx_load = 1; tx_start = 10'd70; tx_len = 11'd8;
    @(negedge clk); tx_load = 0;
    repeat (10) @(negedge clk);
    check("R10 stale words prefetched", DW'(tx_valid), 16'd1);
    tx_read(10'd64, 5);
    tx_stall = 0;
    wait_drain("R10 reload drains");
    repeat (10) @(negedge clk);
    check("R5 R10 no word beyond count", DW'(tx_valid), 16'd0);

    // R8 receive never refused while host and transmit contend
    rx_waits = 0;
    fork
      host_write(10'd88, 12);
      tx_read(10'd68, 20);
      rx_stream(10'd18, 16, 1);
    join
    wait_drain("R7 contention phase drains");
    repeat (5) @(negedge clk);
    check("R8 receive refusals", DW'(rx_waits), 16'd0);

    for (int a = int'(RXLO); a <= int'(RXHI); a++) check("R2 receive region content", ram[a], sh[a]);
    for (int a = int'(TXLO); a <= int'(TXHI); a++) check("R3 transmit region content", ram[a], sh[a]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule